// File: doc/BRIEF.md
# Set-Dueling Insertion Controller

This block decides where a newly filled line enters the replacement priority list of one cache set: at the head (most-recently-used position) or at the tail (least-recently-used position). Two policies compete. One always puts the new line at the head. The other is bimodal. It puts the line at the tail unless a pseudo-random draw succeeds, which happens about once in 32 fills. A line that lands at the tail survives only if it is referenced again before the next eviction, so a streaming or thrashing working set cannot flush the useful part of the cache.

A small sample of sets is pinned to each policy, and each of those sets keeps its policy whatever happens. Every miss in one of these sampled sets moves a saturating selector counter, up for the head-policy sample and down for the bimodal sample. The counter's top bit picks the policy that all other sets use. The cache controller presents every lookup with its set index and a miss flag. For each miss, one cycle later, the block returns a registered valid pulse and a head or tail decision. A per-instance offset parameter moves the sampled sets, so that caches sitting next to each other in a multi-core system sample different sets.

Top module: `ins_duel_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `ins_vld` and `ins_head` at 0. The synchronous reset sets the selector to its midpoint 512, where the top bit is 1 and follower sets use the bimodal rule. It seeds the random generator with 0xACE1.
- R2: A fill is a cycle with `acc_vld` and `acc_miss` both high. After the rising edge that samples a fill, `ins_vld` is 1 for exactly one cycle. After any other edge it is 0, and `ins_head` is then 0 as well.
- R3: Split the set index into a high half `acc_set[9:5]` and a low half `acc_set[4:0]`. With the default offset 0, a set is a head-policy sample when the high half equals the low half. It is a bimodal sample when the high half equals the bitwise complement of the low half. Every other set is a follower. The offset is XORed onto the low half before both comparisons.
- R4: A fill in a head-policy sample set always returns `ins_head` = 1.
- R5: A fill in a bimodal sample set returns `ins_head` = 1 only when the five low bits of the random generator are all zero, and 0 otherwise. The selector has no influence on this result.
- R6: The random generator is a 16-bit register. Each fill shifts it left by one. The new bit 0 is bit 15 XOR bit 13 XOR bit 12 XOR bit 10. A decision uses the value held before that fill's shift. Cycles without a fill leave it unchanged, and it never becomes zero.
- R7: A fill in a head-policy sample set adds 1 to the 10-bit selector. A fill in a bimodal sample set subtracts 1. Follower fills leave the selector unchanged.
- R8: The selector saturates. It stays at 1023 when incremented there and stays at 0 when decremented there.
- R9: A follower fill uses the bimodal rule of R5 when the selector's top bit is 1 (value 512 or above) and returns head when the top bit is 0. The selector value used is the one before the edge that samples the fill.
- R10: Hits (`acc_vld` high, `acc_miss` low) and miss flags raised without `acc_vld` change neither the selector nor the random generator, and produce no output.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| acc_vld | input | 1 | A lookup is presented this cycle |
| acc_miss | input | 1 | The presented lookup missed and a line will be filled |
| acc_set | input | SET_W (10) | Set index of the lookup |
| ins_vld | output | 1 | Registered: an insertion decision is valid |
| ins_head | output | 1 | Registered: 1 inserts at head (MRU), 0 at tail (LRU) |

## Verification
Each decision is due in the cycle that follows the rising edge that sampled its fill, since there is one output register and no other stage. The bench drives inputs just after a falling edge and compares both outputs at the next falling edge, so every comparison falls midway between the sampling edge and the edge after it. The selector and the random generator update on that same sampling edge. Their effect therefore first shows on the next fill, and the bench's model follows this order: it computes the decision from the old values and only then applies the updates. The policy flips at the saturation limits and around the midpoint are checked by counting exact numbers of sample-set misses. A follower fill then shows which policy is in force.

// File: rtl/ins_duel_pkg.sv
package ins_duel_pkg;

  // Role of a set in the duel between the two insertion policies.
  typedef enum logic [1:0] {
    KIND_FOLLOW    = 2'd0,
    KIND_LEAD_HEAD = 2'd1,
    KIND_LEAD_BIMO = 2'd2
  } set_kind_e;

  // Registered decision presented at the block's output.
  typedef struct packed {
    logic vld;
    logic head;
  } ins_dec_t;

endpackage

// File: rtl/ins_set_classify.sv
module ins_set_classify
  import ins_duel_pkg::*;
#(
  parameter int unsigned SET_W      = 10,
  parameter int unsigned LEADER_OFS = 0
) (
  input  logic [SET_W-1:0] set_idx,
  output set_kind_e        kind
);

  localparam int unsigned HALF = SET_W / 2;
  localparam logic [HALF-1:0] OFS_V = HALF'(LEADER_OFS);

  logic [HALF-1:0] hi_f;
  logic [HALF-1:0] lo_f;
  logic            eq_same;
  logic            eq_inv;

  // With an odd width the top bit is left out of the comparison.
  generate
    if ((SET_W % 2) == 0) begin : g_even
      assign hi_f = set_idx[SET_W-1 -: HALF];
    end else begin : g_odd
      logic unused_top;
      assign unused_top = set_idx[SET_W-1];
      assign hi_f = set_idx[SET_W-2 -: HALF];
    end
  endgenerate

  assign lo_f    = set_idx[HALF-1:0] ^ OFS_V;
  assign eq_same = (hi_f == lo_f);
  assign eq_inv  = (hi_f == ~lo_f);

  always_comb begin
    if (eq_same)     kind = KIND_LEAD_HEAD;
    else if (eq_inv) kind = KIND_LEAD_BIMO;
    else             kind = KIND_FOLLOW;
  end

endmodule

// File: rtl/ins_lfsr.sv
module ins_lfsr #(
  parameter int unsigned     LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
  parameter int unsigned     RND_BITS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic              draw_hit,
  output logic [LFSR_W-1:0] state
);

  logic [LFSR_W-1:0] state_q;
  logic              fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk) begin
    if (rst)      state_q <= SEED;
    else if (adv) state_q <= {state_q[LFSR_W-2:0], fb};
  end

  // Low bits all zero: probability 2^-RND_BITS per draw.
  assign draw_hit = (state_q[RND_BITS-1:0] == '0);
  assign state    = state_q;

endmodule

// File: rtl/ins_psel_ctr.sv
module ins_psel_ctr #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic             top_bit,
  output logic [CNT_W-1:0] value
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MID = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_MID;
    end else if (inc && !dec) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (dec && !inc) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign top_bit = cnt_q[CNT_W-1];
  assign value   = cnt_q;

endmodule

// File: rtl/ins_duel_ctrl.sv
module ins_duel_ctrl
  import ins_duel_pkg::*;
#(
  parameter int unsigned       SET_W      = 10,
  parameter int unsigned       CNT_W      = 10,
  parameter int unsigned       LFSR_W     = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS  = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED  = 16'hACE1,
  parameter int unsigned       RND_BITS   = 5,
  parameter int unsigned       LEADER_OFS = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_vld,
  input  logic             acc_miss,
  input  logic [SET_W-1:0] acc_set,
  output logic             ins_vld,
  output logic             ins_head
);

  set_kind_e         kind;
  logic              fill;
  logic              draw_hit;
  logic              psel_top;
  logic [CNT_W-1:0]  psel_val;
  logic [LFSR_W-1:0] lfsr_val;
  logic              head_d;
  ins_dec_t          dec_q;

  assign fill = acc_vld & acc_miss;

  ins_set_classify #(
    .SET_W      (SET_W),
    .LEADER_OFS (LEADER_OFS)
  ) u_class (
    .set_idx (acc_set),
    .kind    (kind)
  );

  ins_psel_ctr #(
    .CNT_W (CNT_W)
  ) u_psel (
    .clk     (clk),
    .rst     (rst),
    .inc     (fill && (kind == KIND_LEAD_HEAD)),
    .dec     (fill && (kind == KIND_LEAD_BIMO)),
    .top_bit (psel_top),
    .value   (psel_val)
  );

  ins_lfsr #(
    .LFSR_W   (LFSR_W),
    .TAPS     (LFSR_TAPS),
    .SEED     (LFSR_SEED),
    .RND_BITS (RND_BITS)
  ) u_rng (
    .clk      (clk),
    .rst      (rst),
    .adv      (fill),
    .draw_hit (draw_hit),
    .state    (lfsr_val)
  );

  always_comb begin
    unique case (kind)
      KIND_LEAD_HEAD: head_d = 1'b1;
      KIND_LEAD_BIMO: head_d = draw_hit;
      default:        head_d = psel_top ? draw_hit : 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q <= '0;
    end else begin
      dec_q.vld  <= fill;
      dec_q.head <= fill & head_d;
    end
  end

  assign ins_vld  = dec_q.vld;
  assign ins_head = dec_q.head;

endmodule

// File: rtl/ins_duel_chk.sv
module ins_duel_chk #(
  parameter int unsigned SET_W      = 10,
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned LFSR_W     = 16,
  parameter int unsigned LEADER_OFS = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_vld,
  input logic              acc_miss,
  input logic [SET_W-1:0]  acc_set,
  input logic              ins_vld,
  input logic              ins_head,
  input logic [CNT_W-1:0]  cnt,
  input logic [LFSR_W-1:0] lfsr
);

  localparam int unsigned      HALF  = SET_W / 2;
  localparam logic [HALF-1:0]  OFS_V = HALF'(LEADER_OFS);
  localparam logic [CNT_W-1:0] C_MAX = '1;
  localparam logic [CNT_W-1:0] C_MID = {1'b1, {(CNT_W-1){1'b0}}};

  logic fill, is_hd, is_bm, is_fo;
  assign fill  = acc_vld && acc_miss;
  assign is_hd = (acc_set[SET_W-1 -: HALF] == (acc_set[HALF-1:0] ^ OFS_V));
  assign is_bm = (acc_set[SET_W-1 -: HALF] == ~(acc_set[HALF-1:0] ^ OFS_V));
  assign is_fo = !is_hd && !is_bm;

  AST_RST_QUIET: assert property (@(posedge clk) rst |=> (!ins_vld && !ins_head)); // R1
  AST_RST_MID: assert property (@(posedge clk) rst |=> (cnt == C_MID)); // R1
  AST_FILL_PULSE: assert property (@(posedge clk) disable iff (rst) fill |=> ins_vld); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !fill |=> (!ins_vld && !ins_head)); // R2
  AST_HEAD_LEADER: assert property (@(posedge clk) disable iff (rst) (fill && is_hd) |=> ins_head); // R4
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst) lfsr != '0); // R6
  AST_CNT_UP: assert property (@(posedge clk) disable iff (rst)
    (fill && is_hd && cnt != C_MAX) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R7
  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (fill && is_bm && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (fill && is_hd && cnt == C_MAX) |=> (cnt == C_MAX)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (fill && is_bm && cnt == '0) |=> (cnt == '0)); // R8
  AST_FOLLOW_MRU: assert property (@(posedge clk) disable iff (rst)
    (fill && is_fo && !cnt[CNT_W-1]) |=> ins_head); // R9
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(fill && !is_fo) |=> $stable(cnt)); // R10
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst) !fill |=> $stable(lfsr)); // R10

endmodule

bind ins_duel_ctrl ins_duel_chk #(
  .SET_W      (SET_W),
  .CNT_W      (CNT_W),
  .LFSR_W     (LFSR_W),
  .LEADER_OFS (LEADER_OFS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .acc_vld  (acc_vld),
  .acc_miss (acc_miss),
  .acc_set  (acc_set),
  .ins_vld  (ins_vld),
  .ins_head (ins_head),
  .cnt      (psel_val),
  .lfsr     (lfsr_val)
);

// File: tb/ins_duel_ctrl_tb_top.sv
`timescale 1ns/1ps
module ins_duel_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_vld = 1'b0;
  logic       acc_miss = 1'b0;
  logic [9:0] acc_set = '0;
  logic       ins_vld;
  logic       ins_head;

  int         n_chk = 0;
  int         n_fail = 0;
  int         ref_cnt = 512;
  logic [15:0] ref_rng = 16'hACE1;
  string      phase = "";

  always #4 clk = ~clk;

  ins_duel_ctrl dut_i (
    .clk      (clk),
    .rst      (rst),
    .acc_vld  (acc_vld),
    .acc_miss (acc_miss),
    .acc_set  (acc_set),
    .ins_vld  (ins_vld),
    .ins_head (ins_head)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s %s: actual %0b expected %0b", req, phase, what, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, model, compare at the next falling edge.
  task automatic step(input logic v, input logic m, input logic [9:0] s);
    logic [4:0] hi = s[9:5];
    logic [4:0] lo = s[4:0];
    logic ev = v && m;
    logic eh = 1'b0;
    logic rz;
    string tag = v ? "R10" : "R2";
    acc_vld = v; acc_miss = m; acc_set = s;
    if (ev) begin
      rz = (ref_rng[4:0] == 5'd0);
      if (hi == lo) begin
        eh = 1'b1; tag = "R3 R4 R7";
        if (ref_cnt < 1023) ref_cnt++;
      end else if (hi == ~lo) begin
        eh = rz; tag = "R3 R5 R6 R7";
        if (ref_cnt > 0) ref_cnt--;
      end else begin
        eh = (ref_cnt >= 512) ? rz : 1'b1; tag = "R3 R6 R9";
      end
      ref_rng = {ref_rng[14:0], ref_rng[15] ^ ref_rng[13] ^ ref_rng[12] ^ ref_rng[10]};
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "ins_vld", ins_vld, ev);
    check(tag, "ins_head", ins_head, eh);
  endtask

  function automatic logic [9:0] set_head(input logic [4:0] lo);
    return {lo, lo};
  endfunction
  function automatic logic [9:0] set_bimo(input logic [4:0] lo);
    return {~lo, lo};
  endfunction
  function automatic logic [9:0] set_follow(input logic [4:0] lo);
    return {lo ^ 5'd1, lo};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    check("R1", "ins_vld reset", ins_vld, 1'b0);
    check("R1", "ins_head reset", ins_head, 1'b0);
    rst = 1'b0;
    // Idle and reset-state follower policy (bimodal at midpoint).
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 10'd0);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, set_follow(5'(i)));
    // Hits and stray miss flags must not move the selector.
    phase = "R10";
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, set_bimo(5'(i)));
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, set_bimo(5'(i)));
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, set_follow(5'(i)));
    // One bimodal-sample miss: 512 -> 511, followers go to head.
    phase = "R9 flip down";
    step(1'b1, 1'b1, set_bimo(5'd3));
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, set_follow(5'(i)));
    phase = "R9 flip up";
    step(1'b1, 1'b1, set_head(5'd7));
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, set_follow(5'(i)));
    // Upper saturation, then exactly 512 decrements to flip.
    phase = "R8 top";
    for (int i = 0; i < 600; i++) step(1'b1, 1'b1, set_head(5'(i)));
    for (int i = 0; i < 511; i++) step(1'b1, 1'b1, set_bimo(5'(i)));
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, set_follow(5'(i)));
    step(1'b1, 1'b1, set_bimo(5'd9));
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, set_follow(5'(i)));
    // Lower saturation, then exactly 512 increments to flip.
    phase = "R8 bottom";
    for (int i = 0; i < 600; i++) step(1'b1, 1'b1, set_bimo(5'(i)));
    for (int i = 0; i < 511; i++) step(1'b1, 1'b1, set_head(5'(i)));
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, set_follow(5'(i)));
    step(1'b1, 1'b1, set_head(5'd2));
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, set_follow(5'(i)));
    // Mixed traffic across all sets.
    phase = "mixed";
    for (int i = 0; i < 4000; i++) begin
      int pick = $urandom_range(0, 3);
      logic [4:0] lo = 5'($urandom_range(0, 31));
      logic [9:0] s = (pick == 0) ? set_head(lo) :
                      (pick == 1) ? set_bimo(lo) : 10'($urandom_range(0, 1023));
      step($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0, s);
    end
    acc_vld = 1'b0; acc_miss = 1'b0;
    summary();
    $finish;
  end

endmodule